// File: doc/BRIEF.md
# BCD Calendar Clock with Buffered Register Window

This block keeps calendar time: century, year, month, date, weekday, hours, minutes and seconds. Every field is packed BCD and hours run 00 to 23. A single-cycle tick input, pulsed once per second, advances the running counters. The calendar step knows the length of each month. It applies the leap-year rule to February.

The host sees the clock through eight byte registers at the top of a 15-bit byte address space. Any other address selected on the bus raises a memory select output, so a RAM can sit underneath. The host never touches the running counters directly. It works on a user copy that follows the counters one cycle behind. A control bit freezes that copy so several bytes can be read as one coherent snapshot. A second control bit stages writes in the copy and transfers them to the counters when it is cleared. Reads never see a half-updated time, and the counters keep stepping during ordinary reads.

A supply-fault input shuts the bus out completely. While it is high the block drives no data, takes no write and raises no memory select.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: Addresses 0x7FF8 to 0x7FFF select the clock registers. Any other selected address raises `mem_sel` and leaves `rd_drive` low.
- R2: Register layout: 0x7FF8 control is {bit7 write-hold, bit6 freeze, bits 5:0 century}. Then seconds at 0x7FF9, minutes 0x7FFA, hours 0x7FFB, weekday 0x7FFC, date 0x7FFD, month 0x7FFE and year 0x7FFF.
- R3: Seconds and minutes roll from 59 to 00 with carry. Hours roll from 23 to 00 with carry. All values are in packed BCD.
- R4: The date rolls to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in all other months except February. Month 12 rolls to 01 with carry into the year.
- R5: February ends on day 29 when the BCD year is divisible by 4, year 00 included, and on day 28 otherwise.
- R6: Year 99 rolls to 00 and increments the BCD century. Century 39 wraps to 00.
- R7: While freeze is set, register reads hold their value as ticks arrive. After freeze clears, reads show the counters with every tick counted.
- R8: While write-hold is set, the counters stop and writes to the registers are staged in the user copy. Century bits are taken only while hold is already set. A control write that clears hold loads the staged values into the counters. Time-register writes made without hold have no effect.
- R9: `rd_drive` is high only when select and output enable are high and write enable is low. A write takes place only when select and write enable are both high.
- R10: While `pwr_fault` is high, `rd_drive` and `mem_sel` stay low and register writes are ignored. The counters keep advancing.
- R11: After reset the registers read 00:00:00, weekday 01, date 01, month 01, year 00, century 20, with hold and freeze clear.
- R12: The weekday advances at midnight and wraps from 7 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| pwr_fault | input | 1 | Supply out of tolerance; locks out the bus |
| bus_addr | input | 15 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_sel | input | 1 | Chip select, active high |
| bus_oe | input | 1 | Output enable, active high |
| bus_we | input | 1 | Write enable, active high |
| rd_data | output | 8 | Read data, zero when not driving |
| rd_drive | output | 1 | Read data is valid and the bus should be driven |
| mem_sel | output | 1 | Access belongs to the memory below the register window |

## Verification
The bench builds the block with its default parameters: a 15-bit address and a reset century of 20. This puts the register window at 0x7FF8 to 0x7FFF. Loading times just before a boundary through the write-hold path lets single ticks reach each rollover: month ends, both February cases, year 00 as a leap year, and the century carry. Directed sequences cover freeze, staging, the ignored unheld writes and the supply-fault lockout.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef struct packed {
      logic [7:0] cen;
      logic [7:0] yr;
      logic [7:0] mon;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hr;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   function automatic logic is_leap(input logic [7:0] yr);
      logic [6:0] b;
      b = {3'd0, yr[7:4]} * 7'd10 + {3'd0, yr[3:0]};
      return (b[1:0] == 2'b00);
   endfunction

   function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
   import rtc_pkg::*;
#(
   parameter logic [7:0] RESET_CENTURY = 8'h20,
   parameter logic [7:0] CENTURY_LAST  = 8'h39
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      hold,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t cnt
);

   localparam rtc_time_t RESET_TIME = '{cen: RESET_CENTURY, yr: 8'h00, mon: 8'h01,
                                        date: 8'h01, dow: 8'h01, hr: 8'h00,
                                        min: 8'h00, sec: 8'h00};

   rtc_time_t nxt;
   logic [7:0] last_day;

   assign last_day = month_last(cnt.mon, cnt.yr);

   always_comb begin
      nxt = cnt;
      if (cnt.sec != 8'h59) nxt.sec = bcd_inc(cnt.sec);
      else begin
         nxt.sec = 8'h00;
         if (cnt.min != 8'h59) nxt.min = bcd_inc(cnt.min);
         else begin
            nxt.min = 8'h00;
            if (cnt.hr != 8'h23) nxt.hr = bcd_inc(cnt.hr);
            else begin
               nxt.hr  = 8'h00;
               nxt.dow = (cnt.dow >= 8'h07) ? 8'h01 : bcd_inc(cnt.dow);
               if (cnt.date != last_day) nxt.date = bcd_inc(cnt.date);
               else begin
                  nxt.date = 8'h01;
                  if (cnt.mon != 8'h12) nxt.mon = bcd_inc(cnt.mon);
                  else begin
                     nxt.mon = 8'h01;
                     if (cnt.yr != 8'h99) nxt.yr = bcd_inc(cnt.yr);
                     else begin
                        nxt.yr  = 8'h00;
                        nxt.cen = (cnt.cen >= CENTURY_LAST) ? 8'h00 : bcd_inc(cnt.cen);
                     end
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= RESET_TIME;
      else if (load)            cnt <= load_val;
      else if (tick && !hold)   cnt <= nxt;
   end

   assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !hold && !load && cnt.sec == 8'h59) |=> (cnt.sec == 8'h00));

   assert_month_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !hold && !load && cnt.sec == 8'h59 && cnt.min == 8'h59 &&
       cnt.hr == 8'h23 && cnt.date == last_day) |=> (cnt.date == 8'h01));

   assert_hold_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !load) |=> $stable(cnt));

   assert_load_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_pkg::*;
#(
   parameter int         ADDR_W        = 15,
   parameter int         SLOT_BITS     = 3,
   parameter logic [7:0] RESET_CENTURY = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              sel,
   input  logic              oe,
   input  logic              we,
   input  logic              pwr_fault,
   input  rtc_time_t         cnt,
   output logic [7:0]        rdata,
   output logic              rd_en,
   output logic              mem_en,
   output logic              hold,
   output logic              load,
   output rtc_time_t         load_val
);

   localparam int SLOTS  = 1 << SLOT_BITS;
   localparam int HI_W   = ADDR_W - SLOT_BITS;
   localparam rtc_time_t RESET_TIME = '{cen: RESET_CENTURY, yr: 8'h00, mon: 8'h01,
                                        date: 8'h01, dow: 8'h01, hr: 8'h00,
                                        min: 8'h00, sec: 8'h00};

   if (SLOT_BITS != 3) begin : g_bad_slots
      $error("rtc_regfile: eight register slots are required");
   end
   if (ADDR_W <= SLOT_BITS) begin : g_bad_addr
      $error("rtc_regfile: address too narrow for register window");
   end

   rtc_time_t  shadow;
   logic       freeze_q;
   logic       in_window, bus_ok, wr_ok;
   logic [SLOTS-1:0] slot_hit;
   logic [7:0] slot_val [SLOTS];

   assign in_window = &addr[ADDR_W-1:SLOT_BITS];
   assign bus_ok    = sel && !pwr_fault;
   assign wr_ok     = bus_ok && we && in_window;
   assign rd_en     = bus_ok && oe && !we && in_window;
   assign mem_en    = bus_ok && !in_window;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign slot_hit[g] = wr_ok && (addr[SLOT_BITS-1:0] == SLOT_BITS'(g));
   end

   assign slot_val[0] = {hold, freeze_q, shadow.cen[5:0]};
   assign slot_val[1] = shadow.sec;
   assign slot_val[2] = shadow.min;
   assign slot_val[3] = shadow.hr;
   assign slot_val[4] = shadow.dow;
   assign slot_val[5] = shadow.date;
   assign slot_val[6] = shadow.mon;
   assign slot_val[7] = shadow.yr;

   assign rdata    = rd_en ? slot_val[addr[SLOT_BITS-1:0]] : 8'h00;
   assign load     = slot_hit[0] && hold && !wdata[7];
   assign load_val = shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow   <= RESET_TIME;
         hold     <= 1'b0;
         freeze_q <= 1'b0;
      end else begin
         if (slot_hit[0]) begin
            hold     <= wdata[7];
            freeze_q <= wdata[6];
         end
         if (hold) begin
            if (slot_hit[0] && wdata[7]) shadow.cen <= {2'b00, wdata[5:0]};
            if (slot_hit[1]) shadow.sec  <= wdata;
            if (slot_hit[2]) shadow.min  <= wdata;
            if (slot_hit[3]) shadow.hr   <= wdata;
            if (slot_hit[4]) shadow.dow  <= wdata;
            if (slot_hit[5]) shadow.date <= wdata;
            if (slot_hit[6]) shadow.mon  <= wdata;
            if (slot_hit[7]) shadow.yr   <= wdata;
         end else if (!freeze_q) begin
            shadow <= cnt;
         end
      end
   end

   assert_freeze_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_q && !hold) |=> $stable(shadow));

   assert_fault_lockout_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fault |-> (!rd_en && !mem_en && !load));

   assert_fault_no_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fault |=> ($stable(hold) && $stable(freeze_q)));

   assert_read_gating_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (sel && oe && !we));

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
   import rtc_pkg::*;
#(
   parameter int         ADDR_W        = 15,
   parameter logic [7:0] RESET_CENTURY = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              pwr_fault,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_sel,
   input  logic              bus_oe,
   input  logic              bus_we,
   output logic [7:0]        rd_data,
   output logic              rd_drive,
   output logic              mem_sel
);

   localparam int SLOT_BITS = 3;

   if (RESET_CENTURY[7:6] != 2'b00 || RESET_CENTURY[3:0] > 4'd9) begin : g_bad_cen
      $error("bcd_calendar_rtc: reset century must be six-bit BCD");
   end

   rtc_time_t cnt, load_val;
   logic      hold, load;

   rtc_counter #(
      .RESET_CENTURY (RESET_CENTURY),
      .CENTURY_LAST  (8'h39)
   ) i_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_1hz),
      .hold     (hold),
      .load     (load),
      .load_val (load_val),
      .cnt      (cnt)
   );

   rtc_regfile #(
      .ADDR_W        (ADDR_W),
      .SLOT_BITS     (SLOT_BITS),
      .RESET_CENTURY (RESET_CENTURY)
   ) i_regfile (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .sel       (bus_sel),
      .oe        (bus_oe),
      .we        (bus_we),
      .pwr_fault (pwr_fault),
      .cnt       (cnt),
      .rdata     (rd_data),
      .rd_en     (rd_drive),
      .mem_en    (mem_sel),
      .hold      (hold),
      .load      (load),
      .load_val  (load_val)
   );

endmodule

// File: tb/test_bcd_calendar_rtc.sv
module test_bcd_calendar_rtc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_1hz = 1'b0;
   logic        pwr_fault = 1'b0;
   logic [14:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_sel = 1'b0, bus_oe = 1'b0, bus_we = 1'b0;
   logic [7:0]  rd_data;
   logic        rd_drive, mem_sel;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   bcd_calendar_rtc i_bcd_calendar_rtc (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_fault(pwr_fault),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_sel(bus_sel),
      .bus_oe(bus_oe), .bus_we(bus_we), .rd_data(rd_data),
      .rd_drive(rd_drive), .mem_sel(mem_sel)
   );

   // start {cen,yr,mon,date,dow,hr,min,sec}, expected same order, tick count
   localparam int NV = 11;
   localparam logic [135:0] VEC [NV] = '{
      {64'h20_24_02_28_03_23_59_59, 64'h20_24_02_29_04_00_00_00, 8'd1},
      {64'h20_23_02_28_03_23_59_59, 64'h20_23_03_01_04_00_00_00, 8'd1},
      {64'h20_24_04_30_07_23_59_59, 64'h20_24_05_01_01_00_00_00, 8'd1},
      {64'h20_24_05_30_01_23_59_59, 64'h20_24_05_31_02_00_00_00, 8'd1},
      {64'h20_99_12_31_05_23_59_59, 64'h21_00_01_01_06_00_00_00, 8'd1},
      {64'h20_24_06_15_02_10_09_58, 64'h20_24_06_15_02_10_10_01, 8'd3},
      {64'h20_00_02_28_01_23_59_59, 64'h20_00_02_29_02_00_00_00, 8'd1},
      {64'h20_24_02_29_04_23_59_59, 64'h20_24_03_01_05_00_00_00, 8'd1},
      {64'h20_21_09_30_04_23_59_59, 64'h20_21_10_01_05_00_00_00, 8'd1},
      {64'h20_21_12_31_05_23_59_59, 64'h20_22_01_01_06_00_00_00, 8'd1},
      {64'h39_99_12_31_06_23_59_59, 64'h00_00_01_01_07_00_00_00, 8'd1}
   };

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [14:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_sel = 1'b1; bus_we = 1'b1; bus_oe = 1'b0;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [14:0] a, output logic [7:0] v, output logic en);
      @(negedge clk);
      bus_addr = a; bus_sel = 1'b1; bus_oe = 1'b1; bus_we = 1'b0;
      #1;
      v = rd_data; en = rd_drive;
      bus_sel = 1'b0; bus_oe = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [14:0] a, input logic [7:0] exp);
      logic [7:0] v;
      logic en;
      rd(a, v, en);
      chk(tag, v, exp);
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick_1hz = 1'b1;
         @(negedge clk); tick_1hz = 1'b0;
      end
   endtask

   task automatic set_time(input logic [63:0] t);
      wr(15'h7FF8, 8'h80);
      wr(15'h7FF8, {2'b10, t[61:56]});
      wr(15'h7FFF, t[55:48]);
      wr(15'h7FFE, t[47:40]);
      wr(15'h7FFD, t[39:32]);
      wr(15'h7FFC, t[31:24]);
      wr(15'h7FFB, t[23:16]);
      wr(15'h7FFA, t[15:8]);
      wr(15'h7FF9, t[7:0]);
      wr(15'h7FF8, 8'h00);
   endtask

   task automatic probe(input logic [14:0] a, input logic oe, input logic we,
                        input logic exp_drv, input logic exp_mem, input string tag);
      @(negedge clk);
      bus_addr = a; bus_wdata = 8'h00; bus_sel = 1'b1; bus_oe = oe; bus_we = we;
      #1;
      chk(tag, {7'd0, rd_drive}, {7'd0, exp_drv});
      chk(tag, {7'd0, mem_sel}, {7'd0, exp_mem});
      bus_sel = 1'b0; bus_oe = 1'b0; bus_we = 1'b0;
   endtask

   initial begin : watchdog
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      logic en;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset values, R2 register order
      rd_chk("R11 R2 ctrl", 15'h7FF8, 8'h20);
      rd_chk("R11 R2 sec",  15'h7FF9, 8'h00);
      rd_chk("R11 R2 min",  15'h7FFA, 8'h00);
      rd_chk("R11 R2 hr",   15'h7FFB, 8'h00);
      rd_chk("R11 R2 dow",  15'h7FFC, 8'h01);
      rd_chk("R11 R2 date", 15'h7FFD, 8'h01);
      rd_chk("R11 R2 mon",  15'h7FFE, 8'h01);
      rd_chk("R11 R2 yr",   15'h7FFF, 8'h00);

      // Vector table: R3 R4 R5 R6 R12
      for (int i = 0; i < NV; i++) begin
         logic [63:0] st, ex;
         st = VEC[i][135:72];
         ex = VEC[i][71:8];
         set_time(st);
         ticks(int'(VEC[i][7:0]));
         rd_chk("R6 cen",     15'h7FF8, {2'b00, ex[61:56]});
         rd_chk("R6 yr",      15'h7FFF, ex[55:48]);
         rd_chk("R4 R5 mon",  15'h7FFE, ex[47:40]);
         rd_chk("R4 R5 date", 15'h7FFD, ex[39:32]);
         rd_chk("R12 dow",    15'h7FFC, ex[31:24]);
         rd_chk("R3 hr",      15'h7FFB, ex[23:16]);
         rd_chk("R3 min",     15'h7FFA, ex[15:8]);
         rd_chk("R3 sec",     15'h7FF9, ex[7:0]);
      end

      // R1 address decode
      probe(15'h7FF7, 1'b1, 1'b0, 1'b0, 1'b1, "R1 below window");
      probe(15'h1234, 1'b1, 1'b0, 1'b0, 1'b1, "R1 low memory");
      probe(15'h7FFB, 1'b1, 1'b0, 1'b1, 1'b0, "R1 in window");

      // R9 read gating
      probe(15'h7FF8, 1'b1, 1'b1, 1'b0, 1'b0, "R9 oe with we");
      probe(15'h7FF8, 1'b0, 1'b0, 1'b0, 1'b0, "R9 no oe");

      // R8 staging and transfer
      set_time(64'h20_24_06_15_02_10_09_00);
      wr(15'h7FF9, 8'h45);
      rd_chk("R8 unheld write ignored", 15'h7FF9, 8'h00);
      wr(15'h7FF8, 8'h80);
      wr(15'h7FF9, 8'h30);
      rd_chk("R8 staged read", 15'h7FF9, 8'h30);
      ticks(3);
      wr(15'h7FF8, 8'h00);
      rd_chk("R8 loaded", 15'h7FF9, 8'h30);
      rd_chk("R8 hold cleared", 15'h7FF8, 8'h20);
      ticks(1);
      rd_chk("R8 runs after load", 15'h7FF9, 8'h31);

      // R7 freeze
      wr(15'h7FF8, 8'h40);
      ticks(2);
      rd_chk("R7 frozen", 15'h7FF9, 8'h31);
      rd_chk("R7 freeze bit", 15'h7FF8, 8'h60);
      wr(15'h7FF8, 8'h00);
      rd_chk("R7 no loss", 15'h7FF9, 8'h33);

      // R9 write needs select
      @(negedge clk);
      bus_addr = 15'h7FF8; bus_wdata = 8'h80; bus_sel = 1'b0; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      rd_chk("R9 unselected write", 15'h7FF8, 8'h20);

      // R10 supply fault
      pwr_fault = 1'b1;
      wr(15'h7FF8, 8'h80);
      rd(15'h7FF9, v, en);
      chk("R10 no drive", {7'd0, en}, 8'h00);
      chk("R10 data zero", v, 8'h00);
      probe(15'h0100, 1'b1, 1'b0, 1'b0, 1'b0, "R10 no mem select");
      ticks(1);
      pwr_fault = 1'b0;
      rd_chk("R10 write ignored", 15'h7FF8, 8'h20);
      rd_chk("R10 time kept", 15'h7FF9, 8'h34);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule